// File: doc/BRIEF.md
# Dual-Compare Timer Output Controller

An up-counting timer with two compare values drives a single output pin. When a compare value equals the counter, the matching channel applies its own 2-bit action to the pin. The action can leave the pin unchanged, force it low, force it high or invert it. If both channels match on the same edge, a fixed priority decides the result. A match on channel A can also send a one-cycle start pulse to an external A/D converter. An enable bit gates this pulse.

Software sets up the block through a small synchronous register port. The port holds a control register with both action codes and the trigger enable, the two compare values, a status register with the match flags, and the counter itself. A build parameter selects a channel variant with no trigger. In that variant the trigger enable bit is fixed: it always reads 1 and ignores writes, and no pulse is ever sent.

Top module: `dcmp_timer_out`

## Requirements
- R1: After reset, the following are all 0: counter, control register, both compare registers, the output pin, the trigger pulse and both match flags. In the trigger-less variant, control bit 4 reads 1.
- R2: On each clock with `cnt_en` high, the counter increments and wraps from 255 to 0. Software writes the counter at address 4, and a write takes precedence over counting on the same edge.
- R3: A match on a channel occurs at a clock edge where `cnt_en` is high and the counter equals that channel's compare value. Compare A is at address 1 and compare B at address 2. The effects of a match appear in the cycle after that edge. Without `cnt_en`, nothing matches.
- R4: Control bits [1:0] hold the action code for channel A, and bits [3:2] hold the code for channel B. Each code is chosen independently. The codes are: 00 leaves the pin unchanged, 01 drives it 0, 10 drives it 1, 11 inverts it.
- R5: When both channels match on the same edge, inversion wins over drive-1, and drive-1 wins over drive-0.
- R6: If one coinciding channel has code 00, the other channel's non-zero action applies. If all four action bits are 0, no match changes the pin.
- R7: Control bit 4 enables the trigger. When it is 1, a match on A raises `adc_start` for exactly one cycle, the same cycle the pin update appears. When it is 0, or on a match of B alone, no pulse is sent.
- R8: In the trigger-less variant (`HAS_TRIG`=0), control bit 4 always reads 1, writes to it are ignored, and `adc_start` stays 0.
- R9: The status register is at address 3, with bit 0 for A and bit 1 for B. It is also shown on `match_flags`. A match sets its flag. Writing 0 to a flag bit clears that flag, and writing 1 leaves it unchanged. If a match and a clear reach the same flag on the same edge, the flag ends up set.
- R10: `rdata` shows the register selected by `addr` one cycle later. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| tmr_out | output | 1 | Timer output pin |
| adc_start | output | 1 | One-cycle A/D start request |
| match_flags | output | 2 | Match flags, bit 0 = A, bit 1 = B |

## Verification
The hardest case to reach from the ports is a flag clear that lands on the same edge as a new match of that channel. Only then can set-over-clear priority be seen. The stimulus preloads the counter to the compare value with counting stopped. In a single cycle it then raises the status write of 0 and `cnt_en` together. Coinciding matches are built the same way, by setting both compare values equal to the preloaded count. A second instance with the trigger removed shares every input, so the locked enable bit and the absent pulse are checked against the same traffic.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } act_e;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  localparam int CH_N = 2;
endpackage

// File: rtl/dcmp_counter.sv
module dcmp_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk) begin
    if (rst)      cnt <= '0;
    else if (ld)  cnt <= ld_val;
    else if (en)  cnt <= cnt + 1'b1;
  end

  // R2: count wraps from all-ones to zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (en && !ld && cnt == TOP) |=> (cnt == '0));

  // R2: a load wins over counting
  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/dcmp_compare.sv
module dcmp_compare #(
  parameter int W = 8,
  parameter int N = 2
) (
  input  logic                en,
  input  logic [W-1:0]        cnt,
  input  logic [N-1:0][W-1:0] cmp,
  output logic [N-1:0]        hit
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    assign hit[i] = en && (cnt == cmp[i]);
  end
endmodule

// File: rtl/dcmp_regs.sv
module dcmp_regs
  import dcmp_pkg::*;
#(
  parameter int W        = 8,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic [W-1:0]      cnt,
  input  logic [CH_N-1:0]   hit,
  output act_e              act_a,
  output act_e              act_b,
  output logic              trg_en,
  output logic [W-1:0]      cmp_a,
  output logic [W-1:0]      cmp_b,
  output logic [CH_N-1:0]   flags,
  output logic              cnt_ld,
  output logic [W-1:0]      cnt_ld_val,
  output logic [W-1:0]      rdata
);
  logic         wr_ctrl, wr_stat;
  logic         trg_rd;
  logic [W-1:0] rd_nxt;

  assign wr_ctrl    = wr_en && (addr == A_CTRL);
  assign wr_stat    = wr_en && (addr == A_STAT);
  assign cnt_ld     = wr_en && (addr == A_CNT);
  assign cnt_ld_val = wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_a <= ACT_KEEP;
      act_b <= ACT_KEEP;
      cmp_a <= '0;
      cmp_b <= '0;
    end else begin
      if (wr_ctrl) begin
        act_a <= act_e'(wdata[1:0]);
        act_b <= act_e'(wdata[3:2]);
      end
      if (wr_en && addr == A_CMPA) cmp_a <= wdata;
      if (wr_en && addr == A_CMPB) cmp_b <= wdata;
    end
  end

  if (HAS_TRIG) begin : g_trig
    logic trg_q;
    always_ff @(posedge clk) begin
      if (rst)          trg_q <= 1'b0;
      else if (wr_ctrl) trg_q <= wdata[4];
    end
    assign trg_en = trg_q;
    assign trg_rd = trg_q;
  end else begin : g_notrig
    assign trg_en = 1'b0;
    assign trg_rd = 1'b1;
  end

  for (genvar i = 0; i < CH_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                      flags[i] <= 1'b0;
      else if (hit[i])              flags[i] <= 1'b1;
      else if (wr_stat && !wdata[i]) flags[i] <= 1'b0;
    end

    // R9: a match always leaves its flag set, even against a clear
    p_flag_set_r9: assert property (@(posedge clk) disable iff (rst)
      hit[i] |=> flags[i]);
  end

  always_comb begin
    rd_nxt = '0;
    case (addr)
      A_CTRL: rd_nxt[4:0] = {trg_rd, act_b, act_a};
      A_CMPA: rd_nxt = cmp_a;
      A_CMPB: rd_nxt = cmp_b;
      A_STAT: rd_nxt[CH_N-1:0] = flags;
      A_CNT:  rd_nxt = cnt;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_nxt;
  end
endmodule

// File: rtl/dcmp_out_ctl.sv
module dcmp_out_ctl
  import dcmp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_a,
  input  logic hit_b,
  input  act_e act_a,
  input  act_e act_b,
  input  logic trg_en,
  output logic tmr_out,
  output logic adc_start
);
  logic do_tog, do_high, do_low, out_nxt;

  assign do_tog  = (hit_a && act_a == ACT_TOG)  || (hit_b && act_b == ACT_TOG);
  assign do_high = (hit_a && act_a == ACT_HIGH) || (hit_b && act_b == ACT_HIGH);
  assign do_low  = (hit_a && act_a == ACT_LOW)  || (hit_b && act_b == ACT_LOW);

  always_comb begin
    if (do_tog)       out_nxt = ~tmr_out;
    else if (do_high) out_nxt = 1'b1;
    else if (do_low)  out_nxt = 1'b0;
    else              out_nxt = tmr_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_out   <= 1'b0;
      adc_start <= 1'b0;
    end else begin
      tmr_out   <= out_nxt;
      adc_start <= hit_a && trg_en;
    end
  end

  // R6: with no match the pin holds
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (!hit_a && !hit_b) |=> $stable(tmr_out));

  // R5: any matching toggle inverts the pin
  p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    ((hit_a && act_a == ACT_TOG) || (hit_b && act_b == ACT_TOG))
      |=> (tmr_out != $past(tmr_out)));

  // R5: drive-1 beats drive-0 when no toggle is present
  p_high_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (hit_a && hit_b && act_a == ACT_HIGH && act_b == ACT_LOW) |=> tmr_out);

  // R7: a pulse only follows a match on A
  p_trig_match_r7: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> $past(hit_a));
endmodule

// File: rtl/dcmp_timer_out.sv
module dcmp_timer_out
  import dcmp_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  rdata,
  output logic              tmr_out,
  output logic              adc_start,
  output logic [1:0]        match_flags
);
  logic [CNT_W-1:0]            cnt, cmp_a, cmp_b, ld_val;
  logic [CH_N-1:0][CNT_W-1:0]  cmp_vec;
  logic [CH_N-1:0]             hit;
  logic                        ld, trg_en;
  act_e                        act_a, act_b;

  assign cmp_vec = {cmp_b, cmp_a};

  dcmp_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .ld(ld), .ld_val(ld_val), .cnt(cnt)
  );

  dcmp_compare #(.W(CNT_W), .N(CH_N)) u_cmp (
    .en(cnt_en), .cnt(cnt), .cmp(cmp_vec), .hit(hit)
  );

  dcmp_regs #(.W(CNT_W), .HAS_TRIG(HAS_TRIG)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cnt(cnt), .hit(hit), .act_a(act_a), .act_b(act_b), .trg_en(trg_en),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .flags(match_flags),
    .cnt_ld(ld), .cnt_ld_val(ld_val), .rdata(rdata)
  );

  dcmp_out_ctl u_out (
    .clk(clk), .rst(rst), .hit_a(hit[0]), .hit_b(hit[1]),
    .act_a(act_a), .act_b(act_b), .trg_en(trg_en),
    .tmr_out(tmr_out), .adc_start(adc_start)
  );

  if (!HAS_TRIG) begin : g_lock_chk
    // R8: the trigger-less variant never requests a conversion
    p_lock_no_trig_r8: assert property (@(posedge clk) disable iff (rst)
      !adc_start);
  end
endmodule

// File: tb/dcmp_timer_out_tb.sv
`timescale 1ns/1ps
module dcmp_timer_out_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, rdata2;
  logic       tmr_out, tmr_out2, adc_start, adc_start2;
  logic [1:0] match_flags, match_flags2;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic mdl_out = 1'b0;

  always #2 clk = ~clk;

  dcmp_timer_out dut_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tmr_out(tmr_out), .adc_start(adc_start),
    .match_flags(match_flags)
  );

  dcmp_timer_out #(.HAS_TRIG(1'b0)) dut2_i (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata2), .tmr_out(tmr_out2), .adc_start(adc_start2),
    .match_flags(match_flags2)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic ref_out(logic prev, logic ma, logic mb,
                                   logic [1:0] ca, logic [1:0] cb);
    if ((ma && ca == 2'b11) || (mb && cb == 2'b11)) return ~prev;
    if ((ma && ca == 2'b10) || (mb && cb == 2'b10)) return 1'b1;
    if ((ma && ca == 2'b01) || (mb && cb == 2'b01)) return 1'b0;
    return prev;
  endfunction

  task automatic bus_wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(logic [2:0] a, output logic [7:0] d, output logic [7:0] d2);
    @(negedge clk);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    d = rdata; d2 = rdata2;
  endtask

  task automatic setup(logic [7:0] ctl, logic [7:0] ca, logic [7:0] cb, logic [7:0] c0);
    bus_wr(3'd0, ctl);
    bus_wr(3'd1, ca);
    bus_wr(3'd2, cb);
    bus_wr(3'd4, c0);
    bus_wr(3'd3, 8'h00);
  endtask

  task automatic run_match(string req, logic [7:0] ctl, logic [7:0] ca,
                           logic [7:0] cb, logic [7:0] c0);
    logic ma, mb, e;
    logic [7:0] d, d2;
    setup(ctl, ca, cb, c0);
    ma = (ca == c0);
    mb = (cb == c0);
    e  = ref_out(mdl_out, ma, mb, ctl[1:0], ctl[3:2]);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk); cnt_en = 1'b0;
    chk({req, " pin"}, tmr_out, e);
    chk({req, " pin variant"}, tmr_out2, e);
    chk({req, " R7 trigger"}, adc_start, ma & ctl[4]);
    chk({req, " R8 no trigger"}, adc_start2, 1'b0);
    chk({req, " R9 flags"}, match_flags, {mb, ma});
    mdl_out = e;
    @(negedge clk);
    chk({req, " R7 pulse width"}, adc_start, 1'b0);
    bus_rd(3'd4, d, d2);
    chk({req, " R2 count"}, d, c0 + 8'd1);
  endtask

  task automatic t_reset();
    logic [7:0] d, d2;
    chk("R1 pin", tmr_out, 1'b0);
    chk("R1 trigger", adc_start, 1'b0);
    chk("R1 flags", match_flags, 2'b00);
    for (int a = 0; a < 5; a++) begin
      bus_rd(a[2:0], d, d2);
      chk("R1 register", d, 8'h00);
      chk("R1 variant register", d2, (a == 0) ? 8'h10 : 8'h00);
    end
  endtask

  task automatic t_no_count();
    setup(8'h02, 8'd40, 8'd40, 8'd40);
    repeat (4) @(negedge clk);
    chk("R3 idle pin", tmr_out, mdl_out);
    chk("R3 idle flags", match_flags, 2'b00);
  endtask

  task automatic t_actions();
    run_match("R4 A high", 8'h02, 8'd5, 8'd200, 8'd5);
    run_match("R4 A low", 8'h01, 8'd5, 8'd200, 8'd5);
    run_match("R4 A toggle", 8'h03, 8'd5, 8'd200, 8'd5);
    run_match("R4 A toggle back", 8'h03, 8'd5, 8'd200, 8'd5);
    run_match("R4 B high", 8'h08, 8'd200, 8'd5, 8'd5);
    run_match("R4 B low", 8'h04, 8'd200, 8'd5, 8'd5);
    run_match("R4 B toggle", 8'h0C, 8'd200, 8'd5, 8'd5);
    run_match("R4 B code ignored on A match", 8'h0B, 8'd5, 8'd200, 8'd5);
  endtask

  task automatic t_priority();
    run_match("R5 low vs high", 8'h09, 8'd20, 8'd20, 8'd20);
    run_match("R5 low vs toggle", 8'h0D, 8'd20, 8'd20, 8'd20);
    run_match("R5 high vs low", 8'h06, 8'd20, 8'd20, 8'd20);
    run_match("R5 toggle vs low", 8'h07, 8'd20, 8'd20, 8'd20);
    run_match("R6 keep vs low", 8'h04, 8'd20, 8'd20, 8'd20);
    run_match("R6 high vs keep", 8'h02, 8'd20, 8'd20, 8'd20);
    run_match("R6 all zero hold", 8'h00, 8'd20, 8'd20, 8'd20);
    run_match("R6 all zero single", 8'h00, 8'd20, 8'd99, 8'd20);
  endtask

  task automatic t_trigger();
    logic [7:0] d, d2;
    run_match("R7 enabled A", 8'h12, 8'd60, 8'd200, 8'd60);
    bus_rd(3'd0, d, d2);
    chk("R10 ctrl read", d, 8'h12);
    run_match("R7 enabled B only", 8'h18, 8'd200, 8'd60, 8'd60);
    run_match("R7 disabled", 8'h02, 8'd60, 8'd200, 8'd60);
    bus_rd(3'd0, d, d2);
    chk("R7 ctrl read", d, 8'h02);
    chk("R8 locked bit", d2, 8'h12);
  endtask

  task automatic t_flags();
    logic [7:0] d, d2;
    run_match("R9 both set", 8'h00, 8'd70, 8'd70, 8'd70);
    bus_rd(3'd3, d, d2);
    chk("R10 status read", d, 8'h03);
    bus_wr(3'd3, 8'h01);
    chk("R9 clear B keep A", match_flags, 2'b01);
    bus_wr(3'd3, 8'h02);
    chk("R9 clear A", match_flags, 2'b00);
    // set and clear on the same edge
    setup(8'h02, 8'd30, 8'd200, 8'd30);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd3; wdata = 8'h00; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    chk("R9 set beats clear", match_flags, 2'b01);
    chk("R9 set beats clear pin", tmr_out, 1'b1);
    mdl_out = 1'b1;
  endtask

  task automatic t_counter();
    logic [7:0] d, d2;
    setup(8'h00, 8'd100, 8'd100, 8'd254);
    @(negedge clk); cnt_en = 1'b1;
    @(negedge clk);
    @(negedge clk); cnt_en = 1'b0;
    bus_rd(3'd4, d, d2);
    chk("R2 wrap", d, 8'h00);
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd4; wdata = 8'd77; cnt_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cnt_en = 1'b0;
    bus_rd(3'd4, d, d2);
    chk("R2 write precedence", d, 8'd77);
    bus_rd(3'd1, d, d2);
    chk("R10 cmpA read", d, 8'd100);
    bus_rd(3'd6, d, d2);
    chk("R10 unmapped", d, 8'h00);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_no_count();
    t_actions();
    t_priority();
    t_trigger();
    t_flags();
    t_counter();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule